// File: doc/BRIEF.md
# GPIO Bank Register Block

This block is the register front end for one bank of sixteen general-purpose pins. It sits on a simple memory-mapped bus. The bus has an address, a write strobe, write data, a read strobe and read data that is registered for one cycle. The block holds a per-pin direction register and an output data register. It also provides two write-only command ports: one sets output bits and the other clears them. An input data register shows each pin level after it has passed through a two-stage synchronizer.

Firmware can change single output bits through the set and clear ports. It never needs a read-modify-write sequence to do this, so several software contexts can drive pins of the same bank without a lock. The output data register can also be written as a whole word. Reading it always returns the value the block is driving, not the pin level. This lets software build wired logic by comparing the driven value against the input data register. The block's outputs are the output values and output enables for the pad ring. Pads, pin multiplexing and interrupts are outside this block.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin is an input: the direction register reads 0x0000FFFF, `pin_oe` is all 0, `pin_out` is all 0 and `bus_rdata` is 0.
- R2: The direction register sits at offset 0x00. Bit n set to 1 makes pin n an input with `pin_oe[n]`=0. Bit n set to 0 makes pin n an output with `pin_oe[n]`=1. The change is visible on the cycle after the write, and the register reads back as written.
- R3: A write to offset 0x04 replaces all sixteen output bits at once, and `pin_out` shows the new value on the cycle after the write.
- R4: A write to offset 0x08 drives high each output bit whose write-data bit is 1. Output bits written with 0 keep their value.
- R5: A write to offset 0x0C drives low each output bit whose write-data bit is 1. Output bits written with 0 keep their value.
- R6: Reads at offsets 0x04, 0x08 and 0x0C all return the output data value currently driven on `pin_out`. This holds whatever the pin levels and the direction setting are.
- R7: A read at offset 0x10 returns the pin levels after two register stages. A level applied before clock edge k is returned by a read captured at edge k+2. A read captured at edge k+1 still returns the previous level.
- R8: Writes to offset 0x10 and to unmapped addresses change no register. Unmapped addresses read as 0. Data bits 31:16 are ignored on writes and read as 0.
- R9: Read data is registered. It appears on the cycle after `bus_rd` and keeps its value while `bus_rd` is low.
- R10: Writes on consecutive cycles take effect in order, so when set, direct and clear writes follow each other, the last write decides each bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Raw pin levels from the pads |
| pin_out | output | 16 | Output values to the pads |
| pin_oe | output | 16 | Output enables to the pads, 1 = drive |

## Verification
The bench builds the block with its default parameters: sixteen pins, an 8-bit address, a 32-bit data word and two synchronizer stages. With sixteen pins inside a 32-bit word, the ignored upper data half can be checked on both writes and reads. With two stages, the exact edge at which a new pin level first becomes readable can be located, and the read one edge earlier shown to return the old level. The 8-bit address makes misaligned and out-of-range offsets reachable, so the unmapped decode path can be exercised.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned OFS_DIR  = 'h00;
    localparam int unsigned OFS_DOUT = 'h04;
    localparam int unsigned OFS_SET  = 'h08;
    localparam int unsigned OFS_CLR  = 'h0C;
    localparam int unsigned OFS_DIN  = 'h10;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_DOUT = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_DIN  = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFS_DOUT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFS_DIN);

    always_comb begin
        sel = SEL_NONE;
        if (addr == A_DIR) begin
            sel = SEL_DIR;
        end else if (addr == A_DOUT) begin
            sel = SEL_DOUT;
        end else if (addr == A_SET) begin
            sel = SEL_SET;
        end else if (addr == A_CLR) begin
            sel = SEL_CLR;
        end else if (addr == A_DIN) begin
            sel = SEL_DIN;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = raw_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_comb begin
                stage_d[s] = stage_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned DATA_W   = 32
) (
    input  reg_sel_e              sel,
    input  logic [NUM_PINS-1:0]   dir_val,
    input  logic [NUM_PINS-1:0]   dout_val,
    input  logic [NUM_PINS-1:0]   din_val,
    output logic [DATA_W-1:0]     rd_val
);

    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_DIR:                     rd_val[NUM_PINS-1:0] = dir_val;
            SEL_DOUT, SEL_SET, SEL_CLR:  rd_val[NUM_PINS-1:0] = dout_val;
            SEL_DIN:                     rd_val[NUM_PINS-1:0] = din_val;
            default:                     rd_val = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam logic [NUM_PINS-1:0] DIR_RESET = '1;

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] dout;
        logic [DATA_W-1:0]   rdata;
    } bank_state_t;

    bank_state_t state_d;
    bank_state_t state_q;

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] din_sync;
    logic [DATA_W-1:0]   rd_val;
    logic [NUM_PINS-1:0] wr_bits;

    gpio_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (din_sync)
    );

    gpio_rd_mux #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W)
    ) u_rdmux (
        .sel      (sel),
        .dir_val  (state_q.dir),
        .dout_val (state_q.dout),
        .din_val  (din_sync),
        .rd_val   (rd_val)
    );

    assign wr_bits = bus_wdata[NUM_PINS-1:0];

    always_comb begin
        state_d = state_q;
        if (bus_wr) begin
            unique case (sel)
                SEL_DIR:  state_d.dir  = wr_bits;
                SEL_DOUT: state_d.dout = wr_bits;
                SEL_SET:  state_d.dout = state_q.dout | wr_bits;
                SEL_CLR:  state_d.dout = state_q.dout & ~wr_bits;
                default:  state_d = state_q;
            endcase
        end
        if (bus_rd) begin
            state_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.dir   <= DIR_RESET;
            state_q.dout  <= '0;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pin_out   = state_q.dout;
    assign pin_oe    = ~state_q.dir;
    assign bus_rdata = state_q.rdata;

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);

    localparam logic [ADDR_W-1:0] CK_DIR  = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] CK_DOUT = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] CK_SET  = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] CK_CLR  = ADDR_W'('h0C);

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CK_DIR) |=> (pin_oe == ~$past(bus_wdata[NUM_PINS-1:0]))); // R2

    AST_DOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CK_DOUT) |=> (pin_out == $past(bus_wdata[NUM_PINS-1:0]))); // R3

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CK_SET) |=>
            (pin_out == ($past(pin_out) | $past(bus_wdata[NUM_PINS-1:0])))); // R4

    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CK_CLR) |=>
            (pin_out == ($past(pin_out) & ~$past(bus_wdata[NUM_PINS-1:0])))); // R5

    AST_RD_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CK_DOUT) |=> (bus_rdata[NUM_PINS-1:0] == $past(pin_out))); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PINS] == '0); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_bank_regs_bench.sv
`timescale 1ns/1ps
module gpio_bank_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    gpio_bank_regs u_gpio_bank_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 out", {16'h0, pin_out}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rd(8'h00, v);
        chk("R1 dir", v, 32'h0000FFFF);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(8'h00, 32'hABCD_0F0F);
        chk("R2 oe", {16'h0, pin_oe}, 32'h0000F0F0);
        rd(8'h00, v);
        chk("R2 readback", v, 32'h00000F0F);
    endtask

    task automatic t_dout();
        logic [31:0] v;
        wr(8'h04, 32'h1234_5AA5);
        chk("R3 out", {16'h0, pin_out}, 32'h00005AA5);
        pin_in = 16'hFFFF;
        rd(8'h04, v);
        chk("R6 dout read", v, 32'h00005AA5);
        rd(8'h08, v);
        chk("R6 set read", v, 32'h00005AA5);
        rd(8'h0C, v);
        chk("R6 clr read", v, 32'h00005AA5);
        pin_in = 16'h0000;
    endtask

    task automatic t_set_clr();
        wr(8'h04, 32'h0000_00F0);
        wr(8'h08, 32'hFFFF_0003);
        chk("R4 set", {16'h0, pin_out}, 32'h000000F3);
        wr(8'h08, 32'h0);
        chk("R4 zero keeps", {16'h0, pin_out}, 32'h000000F3);
        wr(8'h0C, 32'hFFFF_0030);
        chk("R5 clr", {16'h0, pin_out}, 32'h000000C3);
        wr(8'h0C, 32'h0);
        chk("R5 zero keeps", {16'h0, pin_out}, 32'h000000C3);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 16'hA5C3;
        rd(8'h10, v);
        chk("R7 early old", v, 32'h0);
        rd(8'h10, v);
        chk("R7 synced", v, 32'h0000A5C3);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(8'h04, 32'h0000_1111);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        chk("R8 out kept", {16'h0, pin_out}, 32'h00001111);
        chk("R8 oe kept", {16'h0, pin_oe}, 32'h0000F0F0);
        rd(8'h10, v);
        chk("R8 din kept", v, 32'h0000A5C3);
        rd(8'h20, v);
        chk("R8 unmapped read", v, 32'h0);
    endtask

    task automatic t_rd_hold();
        logic [31:0] v;
        rd(8'h04, v);
        chk("R9 read", v, 32'h00001111);
        wr(8'h04, 32'h0000_2222);
        repeat (3) @(negedge clk);
        chk("R9 hold", bus_rdata, 32'h00001111);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0000_F000;
        @(negedge clk);
        chk("R10 after set", {16'h0, pin_out}, 32'h0000F222);
        bus_addr = 8'h04; bus_wdata = 32'h0000_0F0F;
        @(negedge clk);
        chk("R10 after dout", {16'h0, pin_out}, 32'h00000F0F);
        bus_addr = 8'h0C; bus_wdata = 32'h0000_0003;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 after clr", {16'h0, pin_out}, 32'h00000F0C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir();
        t_dout();
        t_set_clr();
        t_sync();
        t_ignored();
        t_rd_hold();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule